// File: doc/BRIEF.md
# Asynchronous Serial Transmitter with Clear-to-Send Gating

This block turns characters into asynchronous serial frames on a single output line. A producer hands over one character at a time through a valid/ready port. The character is held in a one-entry holding buffer. When the line is free, it moves into a separate shift register, which sends it as a frame. A frame has a low start bit, then 7, 8 or 9 data bits with the least significant bit first, then an optional parity bit (odd or even), then one or two high stop bits. The line stays high between frames.

The bit period is 16×(n+1) periods of a selected clock, where n is an 8-bit divisor. The selected clock is either the base clock prescaled by 2, 8 or 32, or the rising edges of an external clock input. A frame starts only when all of these hold: transmission is enabled, the holding buffer is full, the transmitter is idle, and (if clear-to-send gating is turned on) the active-low clear-to-send input is low. One interrupt-request output pulses for one cycle. A configuration bit selects whether it pulses when a character leaves the holding buffer or when the whole frame has finished.

Back-pressure works as follows. `in_ready` is high exactly while the holding buffer is empty. A character is taken on a clock edge where `in_valid` and `in_ready` are both high. While `in_ready` is low, `in_valid` and `in_data` are ignored. Because the buffer empties when a frame starts, the producer can queue the next character while the current frame is still on the line.

Top module: `uart_tx_top`

## Requirements
- R1: `txd` is high whenever no frame is in progress. A frame is a 0 start bit followed by the data bits taken from `in_data`, least significant bit first. The number of data bits is set by `cfg_dlen`: 0 gives 7, 1 gives 8, 2 or 3 gives 9.
- R2: When `cfg_par_en`=1, a parity bit follows the data bits. With `cfg_par_odd`=0 the total number of ones in the data bits plus the parity bit is even; with `cfg_par_odd`=1 it is odd. When `cfg_par_en`=0 no parity bit is sent.
- R3: The frame ends with one high stop bit when `cfg_two_stop`=0 and with two when it is 1.
- R4: With `cfg_ext_clk`=0, each bit lasts exactly 16×(`cfg_div`+1)×P base clock cycles. P is 2, 8 or 32 for `cfg_presc` = 0, 1, or 2/3.
- R5: With `cfg_ext_clk`=1, each bit lasts 16×(`cfg_div`+1) rising edges of `ext_clk`.
- R6: `in_ready` is high exactly while the holding buffer is empty. A handshake fills the buffer, and `in_valid` while `in_ready` is low leaves the held character unchanged.
- R7: A full buffer is not started while `tx_en`=0, or while `cfg_cts_en`=1 and `cts_n`=1. The character stays held and `txd` stays high.
- R8: With `cfg_cts_en`=0, the level of `cts_n` has no effect on starting a frame.
- R9: `cts_n` is looked at only when a frame is about to start. A frame in progress always completes unchanged.
- R10: The buffer empties in the cycle in which `txd` falls for the start bit. A character written during a frame is sent right after that frame.
- R11: With `cfg_irq_sel`=0, `irq` pulses for exactly one cycle, in the cycle in which `txd` falls for the start bit.
- R12: With `cfg_irq_sel`=1, `irq` stays low at the start of a frame. It pulses for one cycle when the last stop bit has completed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Base clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ext_clk | input | 1 | External clock; its rising edges are the selected clock when chosen |
| cfg_ext_clk | input | 1 | 1 selects `ext_clk`, 0 selects the prescaled base clock |
| cfg_presc | input | 2 | Base clock prescale: 0 = /2, 1 = /8, 2 or 3 = /32 |
| cfg_div | input | 8 | Divisor n; bit period is 16×(n+1) selected clocks |
| cfg_dlen | input | 2 | Data bits: 0 = 7, 1 = 8, 2 or 3 = 9 |
| cfg_par_en | input | 1 | Send a parity bit |
| cfg_par_odd | input | 1 | 1 = odd parity, 0 = even parity |
| cfg_two_stop | input | 1 | 1 = two stop bits, 0 = one |
| cfg_cts_en | input | 1 | 1 = frame start also needs `cts_n` low |
| cfg_irq_sel | input | 1 | 0 = interrupt on buffer transfer, 1 = interrupt on frame end |
| tx_en | input | 1 | Transmit enable |
| cts_n | input | 1 | Active-low clear-to-send |
| in_valid | input | 1 | Producer offers a character |
| in_ready | output | 1 | Holding buffer empty; character accepted when high with `in_valid` |
| in_data | input | 9 | Character, right-aligned |
| txd | output | 1 | Serial output line |
| irq | output | 1 | One-cycle interrupt request |

## Verification
The bench builds the block with its default parameters: an 8-bit divisor, 7 to 9 data bits, prescalers of 2, 8 and 32, and a two-stage synchroniser on the external clock. Small divisor values keep a bit down to tens of cycles. This makes it possible to sweep every data length, parity mode and stop-bit count, with several data patterns and both interrupt sources. Exact bit periods are measured for each prescaler, and the external clock path is timed within its synchroniser tolerance. Gating by enable and clear-to-send, a clear-to-send change in mid-frame, back-to-back frames and writes rejected by back-pressure are each driven directly.

// File: rtl/uart_tx_pkg.sv
package uart_tx_pkg;

  // Frame format presented to the shift stage
  typedef struct packed {
    logic [1:0] dlen;
    logic       par_en;
    logic       par_odd;
    logic       two_stop;
  } fmt_t;

endpackage

// File: rtl/uart_tx_baud.sv
module uart_tx_baud #(
  parameter int DIV_W       = 8,
  parameter int OVERSAMPLE  = 16,
  parameter int PRE_A       = 2,
  parameter int PRE_B       = 8,
  parameter int PRE_C       = 32,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic             ext_clk,
  input  logic             cfg_ext,
  input  logic [1:0]       cfg_presc,
  input  logic [DIV_W-1:0] cfg_div,
  output logic             bit_tick
);
  localparam int PW = $clog2(PRE_C);
  localparam int OW = $clog2(OVERSAMPLE);
  localparam int BW = DIV_W + OW;

  logic [PW-1:0]        pre_q, pre_lim;
  logic                 int_tick, ext_rise, src_tick;
  logic [SYNC_STAGES:0] sync_q;
  logic [BW-1:0]        bit_q, bit_lim;

  always_comb begin
    case (cfg_presc)
      2'd0:    pre_lim = PW'(PRE_A - 1);
      2'd1:    pre_lim = PW'(PRE_B - 1);
      default: pre_lim = PW'(PRE_C - 1);
    endcase
  end

  assign int_tick = (pre_q == pre_lim);

  // Prescaler restarts with every frame so the bit period is exact
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                 pre_q <= '0;
    else if (!run || int_tick)  pre_q <= '0;
    else                        pre_q <= pre_q + 1'b1;
  end

  // External clock: synchroniser chain plus one stage for edge detect
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[SYNC_STAGES-1:0], ext_clk};
  end

  assign ext_rise = sync_q[SYNC_STAGES-1] & ~sync_q[SYNC_STAGES];
  assign src_tick = cfg_ext ? ext_rise : int_tick;

  // 16*(n+1)-1 for a power-of-two oversample factor
  assign bit_lim = {cfg_div, {OW{1'b1}}};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        bit_q <= '0;
    else if (!run)     bit_q <= '0;
    else if (src_tick) bit_q <= (bit_q == bit_lim) ? '0 : bit_q + 1'b1;
  end

  assign bit_tick = run && src_tick && (bit_q == bit_lim);

endmodule

// File: rtl/uart_tx_shift.sv
module uart_tx_shift
  import uart_tx_pkg::*;
#(
  parameter int DMIN = 7,
  parameter int DMAX = 9
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            load,
  input  logic [DMAX-1:0] data,
  input  fmt_t            fmt,
  input  logic            bit_tick,
  output logic            txd,
  output logic            busy,
  output logic            done
);
  localparam int FW = DMAX + 4;
  localparam int CW = $clog2(FW + 1);

  logic [FW-1:0] frame, sh_q;
  logic [CW-1:0] dbits, nbits, rem_q;
  logic [CW-1:0] dsum;
  logic          par;
  logic          busy_q;

  assign dsum  = CW'(DMIN) + CW'(fmt.dlen);
  assign dbits = (dsum > CW'(DMAX)) ? CW'(DMAX) : dsum;
  assign nbits = dbits + CW'(2) + CW'(fmt.par_en) + CW'(fmt.two_stop);

  always_comb begin
    frame    = '1;
    frame[0] = 1'b0;
    par      = fmt.par_odd;
    for (int j = 0; j < DMAX; j++) begin
      if (j < int'(dbits)) begin
        frame[j+1] = data[j];
        par        = par ^ data[j];
      end
    end
    if (fmt.par_en) frame[int'(dbits)+1] = par;
  end

  assign done = busy_q && bit_tick && (rem_q == CW'(1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_q   <= '1;
      rem_q  <= '0;
      busy_q <= 1'b0;
    end else if (load) begin
      sh_q   <= frame;
      rem_q  <= nbits;
      busy_q <= 1'b1;
    end else if (busy_q && bit_tick) begin
      sh_q  <= {1'b1, sh_q[FW-1:1]};
      rem_q <= rem_q - 1'b1;
      if (rem_q == CW'(1)) busy_q <= 1'b0;
    end
  end

  assign txd  = sh_q[0];
  assign busy = busy_q;

endmodule

// File: rtl/uart_tx_top.sv
module uart_tx_top
  import uart_tx_pkg::*;
#(
  parameter int DIV_W = 8,
  parameter int DMIN  = 7,
  parameter int DMAX  = 9
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ext_clk,
  input  logic             cfg_ext_clk,
  input  logic [1:0]       cfg_presc,
  input  logic [DIV_W-1:0] cfg_div,
  input  logic [1:0]       cfg_dlen,
  input  logic             cfg_par_en,
  input  logic             cfg_par_odd,
  input  logic             cfg_two_stop,
  input  logic             cfg_cts_en,
  input  logic             cfg_irq_sel,
  input  logic             tx_en,
  input  logic             cts_n,
  input  logic             in_valid,
  output logic             in_ready,
  input  logic [DMAX-1:0]  in_data,
  output logic             txd,
  output logic             irq
);
  logic [DMAX-1:0] hold_q;
  logic            full_q, irq_q;
  logic            start, bit_tick, sh_busy, sh_done;
  fmt_t            fmt;

  assign fmt = '{dlen: cfg_dlen, par_en: cfg_par_en, par_odd: cfg_par_odd,
                 two_stop: cfg_two_stop};

  assign in_ready = !full_q;
  assign start    = full_q && tx_en && !sh_busy && (!cfg_cts_en || !cts_n);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hold_q <= '0;
      full_q <= 1'b0;
    end else if (start) begin
      full_q <= 1'b0;
    end else if (in_valid && !full_q) begin
      hold_q <= in_data;
      full_q <= 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) irq_q <= 1'b0;
    else        irq_q <= cfg_irq_sel ? sh_done : start;
  end

  assign irq = irq_q;

  uart_tx_baud #(.DIV_W(DIV_W)) u_baud (
    .clk      (clk),
    .rst_n    (rst_n),
    .run      (sh_busy),
    .ext_clk  (ext_clk),
    .cfg_ext  (cfg_ext_clk),
    .cfg_presc(cfg_presc),
    .cfg_div  (cfg_div),
    .bit_tick (bit_tick)
  );

  uart_tx_shift #(.DMIN(DMIN), .DMAX(DMAX)) u_shift (
    .clk     (clk),
    .rst_n   (rst_n),
    .load    (start),
    .data    (hold_q),
    .fmt     (fmt),
    .bit_tick(bit_tick),
    .txd     (txd),
    .busy    (sh_busy),
    .done    (sh_done)
  );

endmodule

// File: rtl/uart_tx_chk.sv
module uart_tx_chk (
  input logic clk,
  input logic rst_n,
  input logic tx_en,
  input logic cfg_cts_en,
  input logic cfg_irq_sel,
  input logic cts_n,
  input logic in_valid,
  input logic in_ready,
  input logic txd,
  input logic irq,
  input logic busy,
  input logic done
);
  AST_IDLE_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> txd);                                                  // R1
  AST_LOAD_FULL: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_ready |=> !in_ready);                             // R6
  AST_HOLD_GATED: assert property (@(posedge clk) disable iff (!rst_n)
    !in_ready && (!tx_en || (cfg_cts_en && cts_n)) |=> !in_ready);   // R7
  AST_FRAME_WHOLE: assert property (@(posedge clk) disable iff (!rst_n)
    busy && !done |=> busy);                                         // R9
  AST_IRQ_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    irq |=> !irq);                                                   // R11
  AST_IRQ_AT_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_irq_sel && $rose(in_ready) |-> irq);                        // R11
  AST_NO_IRQ_AT_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_irq_sel && $rose(in_ready) |-> !irq);                        // R12
endmodule

bind uart_tx_top uart_tx_chk u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .tx_en      (tx_en),
  .cfg_cts_en (cfg_cts_en),
  .cfg_irq_sel(cfg_irq_sel),
  .cts_n      (cts_n),
  .in_valid   (in_valid),
  .in_ready   (in_ready),
  .txd        (txd),
  .irq        (irq),
  .busy       (sh_busy),
  .done       (sh_done)
);

// File: tb/uart_tx_top_tb.sv
`timescale 1ns/1ps
module uart_tx_top_tb;
  logic       clk = 1'b0, rst_n = 1'b0, ext_clk = 1'b0;
  logic       cfg_ext_clk = 1'b0, cfg_par_en = 1'b0, cfg_par_odd = 1'b0;
  logic       cfg_two_stop = 1'b0, cfg_cts_en = 1'b0, cfg_irq_sel = 1'b0;
  logic [1:0] cfg_presc = 2'd0, cfg_dlen = 2'd1;
  logic [7:0] cfg_div = 8'd0;
  logic       tx_en = 1'b1, cts_n = 1'b0, in_valid = 1'b0;
  logic [8:0] in_data = '0;
  logic       in_ready, txd, irq;
  int errors = 0, checks = 0;
  bit finished = 1'b0;

  always #5 clk = ~clk;
  always #20 ext_clk = ~ext_clk;

  uart_tx_top u_dut (
    .clk(clk), .rst_n(rst_n), .ext_clk(ext_clk), .cfg_ext_clk(cfg_ext_clk),
    .cfg_presc(cfg_presc), .cfg_div(cfg_div), .cfg_dlen(cfg_dlen),
    .cfg_par_en(cfg_par_en), .cfg_par_odd(cfg_par_odd),
    .cfg_two_stop(cfg_two_stop), .cfg_cts_en(cfg_cts_en),
    .cfg_irq_sel(cfg_irq_sel), .tx_en(tx_en), .cts_n(cts_n),
    .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data),
    .txd(txd), .irq(irq)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic int ndata(input logic [1:0] dl);
    return (dl == 2'd0) ? 7 : (dl == 2'd1) ? 8 : 9;
  endfunction

  function automatic int nbits(input logic [1:0] dl, input logic pe, input logic ts);
    return 1 + ndata(dl) + int'(pe) + 1 + int'(ts);
  endfunction

  function automatic logic [12:0] exp_frame(input logic [8:0] d, input logic [1:0] dl,
                                            input logic pe, input logic po);
    logic [12:0] f;
    int ones;
    int nd;
    f = '1; f[0] = 1'b0; ones = 0; nd = ndata(dl);
    for (int i = 0; i < nd; i++) begin
      f[i+1] = d[i];
      ones += int'(d[i]);
    end
    if (pe) f[nd+1] = po ? ((ones % 2) == 0) : ((ones % 2) == 1);
    return f;
  endfunction

  function automatic int bitper();
    int p;
    p = (cfg_presc == 2'd0) ? 2 : (cfg_presc == 2'd1) ? 8 : 32;
    if (cfg_ext_clk) p = 4;
    return 16 * (int'(cfg_div) + 1) * p;
  endfunction

  task automatic send(input logic [8:0] d);
    @(negedge clk); in_valid = 1'b1; in_data = d;
    @(negedge clk); in_valid = 1'b0;
  endtask

  // Receive one frame from txd by mid-bit sampling and compare
  task automatic decode(input logic [8:0] d, input string req);
    logic [12:0] ex, got;
    int nb, bp, to;
    logic sel;
    string ireq;
    ex = exp_frame(d, cfg_dlen, cfg_par_en, cfg_par_odd);
    nb = nbits(cfg_dlen, cfg_par_en, cfg_two_stop);
    bp = bitper();
    sel = cfg_irq_sel;
    ireq = sel ? "R12 irq at start" : "R11 irq at start";
    got = '1; to = 0;
    while (txd !== 1'b0 && to < 40 * bp) begin @(negedge clk); to++; end
    check(to < 40 * bp, {req, " start seen"}, to, 0);
    check(irq === !sel, ireq, int'(irq), int'(!sel));
    repeat (bp / 2) @(negedge clk);
    for (int k = 0; k < nb; k++) begin
      got[k] = txd;
      if (k < nb - 1) repeat (bp) @(negedge clk);
    end
    check(got == ex, req, int'(got), int'(ex));
    if (sel) begin
      to = 0;
      while (irq !== 1'b1 && to < bp) begin @(negedge clk); to++; end
      check(to < bp && txd === 1'b1, "R12 irq at frame end", to, 0);
    end
  endtask

  // Length of the low run of an all-zero 8N1 character: 9 bit periods
  task automatic measure(input string req, input int tol);
    int bp, n, to;
    bp = bitper(); n = 0; to = 0;
    cfg_dlen = 2'd1; cfg_par_en = 1'b0; cfg_two_stop = 1'b0;
    send(9'h000);
    while (txd !== 1'b0 && to < 100) begin @(negedge clk); to++; end
    while (txd === 1'b0 && n < 20 * bp) begin @(negedge clk); n++; end
    check(n >= 9 * bp - tol && n <= 9 * bp + tol, req, n, 9 * bp);
    repeat (2 * bp) @(negedge clk);
  endtask

  initial begin
    logic [8:0] pats [4];
    pats[0] = 9'h1A5; pats[1] = 9'h05A; pats[2] = 9'h0FF; pats[3] = 9'h100;
    repeat (3) @(negedge clk);
    check(txd === 1'b1, "R1 reset txd", int'(txd), 1);
    check(in_ready === 1'b1, "R6 reset in_ready", int'(in_ready), 1);
    check(irq === 1'b0, "R11 reset irq", int'(irq), 0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // R1 R2 R3 sweep: every length, parity mode, stop count, four patterns
    for (int dl = 0; dl < 3; dl++)
      for (int pm = 0; pm < 3; pm++)
        for (int st = 0; st < 2; st++)
          for (int p = 0; p < 4; p++) begin
            cfg_dlen = 2'(dl); cfg_par_en = (pm != 0); cfg_par_odd = (pm == 2);
            cfg_two_stop = st[0]; cfg_irq_sel = p[0];
            send(pats[p]);
            decode(pats[p], "R1 R2 R3 frame");
            repeat (bitper()) @(negedge clk);
          end
    cfg_irq_sel = 1'b0;

    // R4 exact bit periods per prescaler
    cfg_presc = 2'd0; cfg_div = 8'd2; measure("R4 div2 n2", 0);
    cfg_presc = 2'd1; cfg_div = 8'd1; measure("R4 div8 n1", 0);
    cfg_presc = 2'd2; cfg_div = 8'd0; measure("R4 div32 n0", 0);
    cfg_presc = 2'd3; cfg_div = 8'd0; measure("R4 div32 code3", 0);
    // R5 external clock, 4 base cycles per edge
    cfg_ext_clk = 1'b1; cfg_div = 8'd0; measure("R5 ext clock", 8);
    send(9'h0C3); decode(9'h0C3, "R5 ext frame");
    repeat (bitper()) @(negedge clk);
    cfg_ext_clk = 1'b0; cfg_presc = 2'd0; cfg_div = 8'd0;
    cfg_dlen = 2'd1;

    // R6 R7 held while disabled; rejected write leaves character intact
    tx_en = 1'b0;
    send(9'h03C);
    check(in_ready === 1'b0, "R6 buffer full", int'(in_ready), 0);
    @(negedge clk); in_valid = 1'b1; in_data = 9'h1FF;
    repeat (3) @(negedge clk); in_valid = 1'b0;
    repeat (200) @(negedge clk);
    check(txd === 1'b1 && in_ready === 1'b0, "R7 tx_en low holds", int'(txd), 1);
    tx_en = 1'b1;
    decode(9'h03C, "R6 held char kept");
    repeat (32) @(negedge clk);

    // R7 R9 clear-to-send gating and mid-frame change
    cfg_cts_en = 1'b1; cts_n = 1'b1;
    send(9'h0A7);
    repeat (200) @(negedge clk);
    check(txd === 1'b1 && in_ready === 1'b0, "R7 cts high holds", int'(txd), 1);
    cts_n = 1'b0;
    fork
      decode(9'h0A7, "R9 frame not cut");
      begin repeat (100) @(negedge clk); cts_n = 1'b1; end
    join
    repeat (32) @(negedge clk);
    // R8 gating off ignores cts_n
    cfg_cts_en = 1'b0;
    send(9'h04D);
    decode(9'h04D, "R8 cts ignored");
    cts_n = 1'b0;
    repeat (32) @(negedge clk);

    // R10 back-to-back frames
    fork
      begin decode(9'h011, "R10 first"); decode(9'h0EE, "R10 second"); end
      begin
        send(9'h011);
        repeat (2) @(negedge clk);
        check(in_ready === 1'b1 && txd === 1'b0, "R10 empty at start", int'(in_ready), 1);
        send(9'h0EE);
        check(in_ready === 1'b0, "R10 second queued", int'(in_ready), 0);
      end
    join
    repeat (64) @(negedge clk);

    finished = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (195000) @(posedge clk);
    if (!finished) begin
      checks++; errors++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule